// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets synchronous logic read and write an 8K x 8 asynchronous static RAM. A client presents one request at a time on a valid/ready handshake: a write flag, an address and, for writes, a data byte. The sequencer turns each request into a paced pin sequence on the memory side and answers with a one-cycle done pulse. For reads, the byte fetched from the memory is held on a registered output.

The memory pins are an address bus, an active-low chip select, an active-high chip select, an active-low write strobe and an active-low output enable. The shared data bus is split into an outgoing byte, a driver enable and an incoming byte. Every timing rule of the memory is a parameter counted in clock cycles:

- a power-up wait before the first access;
- the address-settle time before the write strobe falls;
- the strobe width;
- the read access window;
- the bus turnaround after a read.

All pin outputs come straight from flops, so the asynchronous memory never sees a glitch. The controller drives the data bus only while the memory's output enable is high, and it always waits a turnaround gap after a read before it can drive again.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is applied and while idle, the memory is deselected: `mem_cs_n`=1, `mem_cs`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0. `req_ready` and `rsp_done` are 0 during reset. `req_ready` first reads 1 exactly T_PWRUP+2 cycles after reset is released, of which 2 cycles are reset synchronisation.
- R2: A request is taken only in a cycle where `req_ready`=1. While an access is in progress, `req_valid`, `req_addr`, `req_wdata` and `req_write` have no effect on the pins or on the stored data.
- R3: For a write, both chip selects are active with the accepted address for exactly T_ASU cycles with `mem_we_n` high. `mem_we_n` is then low for exactly T_WPW cycles. The address and the outgoing data do not change while the strobe is low.
- R4: The data driver `mem_dq_oe` is on from the first cycle of a write until exactly one cycle after `mem_we_n` returns high, so it is on for T_ASU+T_WPW+1 cycles. It is never on while `mem_oe_n` is low.
- R5: For a read, the chips are selected with `mem_oe_n` low and `mem_we_n` high for exactly T_RACC cycles. The byte on `mem_dq_i` at the end of that window is what `rsp_rdata` shows.
- R6: After a read, `mem_oe_n` is high and the driver is off for exactly T_TURN cycles before done. The controller's driver and the memory's outputs are never on at the same time.
- R7: `rsp_done` is a one-cycle pulse. It occurs T_ASU+T_WPW+2 cycles after a write is accepted and T_RACC+T_TURN+1 cycles after a read is accepted. `req_ready` is 1 in the cycle after `rsp_done`.
- R8: `rsp_rdata` keeps the last read result; writes leave it unchanged.
- R9: `mem_we_n` is low only while both chip selects are active and `mem_oe_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Last read byte |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_o | output | DATA_W | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data driver |
| mem_dq_i | input | DATA_W | Byte returned from the memory bus |

## Verification
The hardest situation to bring about is a data-bus clash, which needs the memory's drivers to still be on when the controller starts driving. The bench models the memory's output enable as releasing one cycle late. It also returns a poison byte until the access window has elapsed, so a turnaround gap that is too short, or a sample taken too early, shows up in the data. Back-to-back reads and writes over every address keep that hand-over happening hundreds of times. Some writes are also followed by a request held on the handshake for the whole access, which would show any effect of requests made while busy.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP  = 3'd0,
    ST_IDLE   = 3'd1,
    ST_WSET   = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WHOLD  = 3'd4,
    ST_RACC   = 3'd5,
    ST_RTURN  = 3'd6,
    ST_DONE   = 3'd7
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic cs;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } pin_ctl_t;

  localparam pin_ctl_t PINS_IDLE = '{cs_n: 1'b1, cs: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

  // Pin levels that belong to each sequencer state.
  function automatic pin_ctl_t pins_for(input seq_state_e st);
    pin_ctl_t p;
    p = PINS_IDLE;
    case (st)
      ST_WSET, ST_WHOLD: begin
        p.cs_n  = 1'b0;
        p.cs    = 1'b1;
        p.dq_oe = 1'b1;
      end
      ST_WPULSE: begin
        p.cs_n  = 1'b0;
        p.cs    = 1'b1;
        p.we_n  = 1'b0;
        p.dq_oe = 1'b1;
      end
      ST_RACC: begin
        p.cs_n = 1'b0;
        p.cs   = 1'b1;
        p.oe_n = 1'b0;
      end
      default: p = PINS_IDLE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    if (load) begin
      cnt_d = load_val;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(RST_VAL);
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned T_ASU  = 1,
  parameter int unsigned T_WPW  = 1,
  parameter int unsigned T_RACC = 1,
  parameter int unsigned T_TURN = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_expired,
  output seq_state_e       state_q,
  output seq_state_e       state_d,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  localparam logic [CNT_W-1:0] LD_ASU  = CNT_W'(T_ASU - 1);
  localparam logic [CNT_W-1:0] LD_WPW  = CNT_W'(T_WPW - 1);
  localparam logic [CNT_W-1:0] LD_RACC = CNT_W'(T_RACC - 1);
  localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(T_TURN - 1);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_PWRUP: begin
        if (tmr_expired) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (req_valid) begin
          tmr_load = 1'b1;
          if (req_write) begin
            state_d = ST_WSET;
            tmr_val = LD_ASU;
          end else begin
            state_d = ST_RACC;
            tmr_val = LD_RACC;
          end
        end
      end
      ST_WSET: begin
        if (tmr_expired) begin
          state_d  = ST_WPULSE;
          tmr_load = 1'b1;
          tmr_val  = LD_WPW;
        end
      end
      ST_WPULSE: begin
        if (tmr_expired) state_d = ST_WHOLD;
      end
      ST_WHOLD: begin
        state_d = ST_DONE;
      end
      ST_RACC: begin
        if (tmr_expired) begin
          state_d  = ST_RTURN;
          tmr_load = 1'b1;
          tmr_val  = LD_TURN;
        end
      end
      ST_RTURN: begin
        if (tmr_expired) state_d = ST_DONE;
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PWRUP;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/sram_seq_datapath.sv
module sram_seq_datapath
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  seq_state_e        state_d,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output pin_ctl_t          pins,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  pin_ctl_t          pins_q;
  pin_ctl_t          pins_d;

  // Pins come from flops loaded with the decode of the next state.
  assign pins_d = pins_for(state_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= PINS_IDLE;
    end else begin
      pins_q <= pins_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= mem_dq_i;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign pins      = pins_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned T_PWRUP = 10000,
  parameter int unsigned T_ASU   = 1,
  parameter int unsigned T_WPW   = 1,
  parameter int unsigned T_RACC  = 1,
  parameter int unsigned T_TURN  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned MAX_A = (T_ASU > T_WPW) ? T_ASU : T_WPW;
  localparam int unsigned MAX_B = (T_RACC > T_TURN) ? T_RACC : T_TURN;
  localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_T = (T_PWRUP > MAX_C) ? T_PWRUP : MAX_C;
  localparam int unsigned CNT_W = (MAX_T < 2) ? 1 : $clog2(MAX_T);

  // Reset: asserted at once, released after two clock edges.
  logic rst_s1_q;
  logic rst_s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  seq_state_e       state_q;
  seq_state_e       state_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             accept;
  logic             capture;
  pin_ctl_t         pins;

  sram_phase_timer #(
    .CNT_W  (CNT_W),
    .RST_VAL(T_PWRUP - 1)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_s2_q),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  sram_seq_fsm #(
    .CNT_W (CNT_W),
    .T_ASU (T_ASU),
    .T_WPW (T_WPW),
    .T_RACC(T_RACC),
    .T_TURN(T_TURN)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_s2_q),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .tmr_expired(tmr_expired),
    .state_q    (state_q),
    .state_d    (state_d),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_done  = (state_q == ST_DONE);
  assign accept    = req_ready & req_valid;
  assign capture   = (state_q == ST_RACC) & tmr_expired;

  sram_seq_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .accept   (accept),
    .capture  (capture),
    .state_d  (state_d),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .mem_dq_i (mem_dq_i),
    .mem_addr (mem_addr),
    .mem_dq_o (mem_dq_o),
    .pins     (pins),
    .rsp_rdata(rsp_rdata)
  );

  assign mem_cs_n  = pins.cs_n;
  assign mem_cs    = pins.cs;
  assign mem_we_n  = pins.we_n;
  assign mem_oe_n  = pins.oe_n;
  assign mem_dq_oe = pins.dq_oe;

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_cs,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe
);

  // R9
  we_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_cs && mem_oe_n));

  // R4
  drv_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R4
  drv_at_we_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  // R4
  drv_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> !mem_dq_oe);

  // R3
  addr_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> ($stable(mem_addr) && $stable(mem_dq_o)));

  // R3
  we_after_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(!mem_cs_n) && $past(mem_cs)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && req_ready));

  // R1
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rsp_done (rsp_done),
  .mem_addr (mem_addr),
  .mem_cs_n (mem_cs_n),
  .mem_cs   (mem_cs),
  .mem_we_n (mem_we_n),
  .mem_oe_n (mem_oe_n),
  .mem_dq_o (mem_dq_o),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_seq_ctrl_bench.sv
module sram_seq_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 8;
  localparam int DW   = 8;
  localparam int NW   = 1 << AW;
  localparam int PWR  = 20;
  localparam int ASU  = 2;
  localparam int WPW  = 3;
  localparam int RACC = 3;
  localparam int TURN = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n;
  logic          mem_cs;
  logic          mem_we_n;
  logic          mem_oe_n;
  logic [DW-1:0] mem_dq_o;
  logic          mem_dq_oe;
  logic [DW-1:0] mem_dq_i;

  int n_tests = 0;
  int n_fail  = 0;
  int clash   = 0;
  bit monitor_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_seq_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .T_PWRUP(PWR), .T_ASU(ASU),
    .T_WPW(WPW), .T_RACC(RACC), .T_TURN(TURN)
  ) u_sram_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  // Memory model: late output release, poison byte before the access time.
  logic [DW-1:0] model_mem [NW];
  logic [DW-1:0] exp_mem   [NW];
  int            rd_cnt;
  logic          hold_q;
  logic          wl_q;
  logic [AW-1:0] wa_q;
  logic [DW-1:0] wd_q;
  logic          read_cond;
  logic          write_cond;
  logic          model_drv;

  assign read_cond  = !mem_cs_n && mem_cs && !mem_oe_n && mem_we_n;
  assign write_cond = !mem_cs_n && mem_cs && !mem_we_n;
  assign model_drv  = read_cond || hold_q;
  assign mem_dq_i   = model_drv ? ((rd_cnt + 1 >= RACC) ? model_mem[mem_addr] : 8'hEE) : 8'h00;

  initial begin
    for (int i = 0; i < NW; i++) model_mem[i] = 8'h5A;
    rd_cnt = 0;
    hold_q = 1'b0;
    wl_q   = 1'b0;
    wa_q   = '0;
    wd_q   = '0;
  end

  always @(posedge clk) begin
    rd_cnt <= read_cond ? rd_cnt + 1 : 0;
    hold_q <= read_cond;
    wl_q   <= write_cond;
    if (write_cond) begin
      wa_q <= mem_addr;
      wd_q <= mem_dq_o;
    end
    if (wl_q && !write_cond) model_mem[wa_q] <= wd_q;
  end

  always @(negedge clk) begin
    if (monitor_on) begin
      if (mem_dq_oe && model_drv) clash = clash + 1;
      if (!mem_we_n && !mem_oe_n) clash = clash + 1;
    end
  end

  function automatic logic [7:0] pat_a(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] pat_b(input int a);
    return 8'((a * 91 + 200) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts and ends just after a falling edge.
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
    int n = 0;
    int setup = 0;
    int pulse = 0;
    int drv = 0;
    bit addr_ok = 1'b1;
    bit done = 1'b0;
    logic [DW-1:0] rd_before;
    rd_before = rsp_rdata;
    req_valid = 1'b1;
    req_write = 1'b1;
    req_addr  = a;
    req_wdata = d;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        if (poke) begin
          // R2: a different request held while busy
          req_write = 1'b0;
          req_addr  = ~a;
          req_wdata = ~d;
        end else begin
          req_valid = 1'b0;
        end
      end
      if (!mem_cs_n && mem_cs) begin
        if (mem_addr != a) addr_ok = 1'b0;
        if (!mem_we_n) pulse++;
        else if (pulse == 0) setup++;
      end
      if (mem_dq_oe) drv++;
      if (rsp_done) done = 1'b1;
    end
    req_valid = 1'b0;
    check(n == ASU + WPW + 2, "R7 write latency", n, ASU + WPW + 2);
    check(setup == ASU, "R3 address settle cycles", setup, ASU);
    check(pulse == WPW, "R3 strobe width", pulse, WPW);
    check(addr_ok, "R3 R2 address held", addr_ok, 1);
    check(drv == ASU + WPW + 1, "R4 driver cycles", drv, ASU + WPW + 1);
    check(rsp_rdata == rd_before, "R8 read data kept over write", rsp_rdata, rd_before);
    @(negedge clk);
    check(req_ready && !rsp_done, "R7 ready after done", req_ready, 1);
    exp_mem[a] = d;
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    int n = 0;
    int oe_low = 0;
    int turn = 0;
    bit done = 1'b0;
    req_valid = 1'b1;
    req_write = 1'b0;
    req_addr  = a;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
      if (n == 1) req_valid = 1'b0;
      if (rsp_done) done = 1'b1;
      else if (!mem_oe_n && !mem_cs_n && mem_cs && mem_we_n) oe_low++;
      else if (oe_low > 0 && mem_oe_n && !mem_dq_oe) turn++;
    end
    check(n == RACC + TURN + 1, "R7 read latency", n, RACC + TURN + 1);
    check(oe_low == RACC, "R5 read window", oe_low, RACC);
    check(turn == TURN, "R6 turnaround cycles", turn, TURN);
    check(rsp_rdata == exp_mem[a], "R5 read data", rsp_rdata, exp_mem[a]);
    @(negedge clk);
    check(req_ready && !rsp_done, "R7 ready after done", req_ready, 1);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    int wait_n;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe,
          "R1 pins in reset", {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    check(!req_ready && !rsp_done, "R1 handshake in reset", {req_ready, rsp_done}, 0);
    rst_n = 1'b1;
    monitor_on = 1'b1;
    wait_n = 0;
    while (!req_ready && wait_n < 1000) begin
      @(negedge clk);
      wait_n++;
    end
    check(wait_n == PWR + 2, "R1 power-up wait", wait_n, PWR + 2);
    check(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe,
          "R1 pins when idle", {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);

    // Sweep every address: write, then read back.
    for (int a = 0; a < NW; a++) do_write(AW'(a), pat_a(a), 1'b0);
    for (int a = 0; a < NW; a++) do_read(AW'(a));

    // Interleaved overwrite and read-back, some with requests held while busy.
    for (int a = 0; a < NW; a += 5) begin
      do_write(AW'(a), pat_b(a), (a % 3) == 0);
      do_read(AW'(a));
      do_read(AW'(~a));
    end

    check(clash == 0, "R6 R9 bus or strobe overlap", clash, 0);
    summary();
    $finish;
  end

endmodule